// File: doc/BRIEF.md
# Per-processor interrupt presenter

This block is the processor-side stage of a two-level interrupt controller. A source controller offers interrupts to it one at a time, each as a source number with a priority, and the block decides whether the offer takes the single pending slot. When an offer takes the slot, it drives an interrupt line into its core. Lower priority numbers are more favored. The processor interacts with the block through four strobes. It can write its current priority, and it can write a priority for an inter-processor interrupt. It can accept the pending interrupt, which reads the 32-bit pending word and pops it. It can signal end-of-interrupt with a 32-bit word.

An offer is refused when it is not favored enough. An offer also displaces a less-favored pending interrupt that came from the source controller. In both cases a reject is bounced back, so that the source controller can retry later. The block also asks the source controller to resend when the processor becomes more permissive, which happens on a less-favored priority write or on end-of-interrupt. A software-requested inter-processor interrupt competes for the same slot under the reserved source number 2. Because it does not belong to the source controller, it is never rejected back.

Only one command acts per clock. If several strobes are high together, the order of precedence is accept, then end-of-interrupt, then current-priority write, then inter-processor priority write, then offer. All state updates and all notification pulses appear one clock after the command.

Top module: `irq_presenter`

## Requirements
- R1: An active-low asynchronous reset sets the pending word to 0x00000000 and the pending priority to 0xFF. It sets the inter-processor priority to 0xFF, lowers the interrupt line and clears all notification pulses.
- R2: The pending word carries the current processor priority in bits 31:24 and the pending source number in bits 23:0. A source field of zero always coincides with a pending priority of 0xFF and a low interrupt line. A nonzero source field always coincides with a high interrupt line.
- R3: An offer is refused, with a reject carrying the offered source number, in two cases. The first is when its priority is greater than or equal to the current priority. The second is when a source is pending whose priority is less than or equal to the offered one. A refused offer leaves the pending word and pending priority unchanged.
- R4: An accepted offer loads its source number and priority and raises the line. If the displaced pending source came from the source controller, it is rejected in the same notification.
- R5: Accept lowers the line and reloads the word with the old pending priority in bits 31:24 and a zero source field. It also sets the pending priority to 0xFF.
- R6: A current-priority write that is more favored than the old value clears a nonempty pending source if the new value is less than or equal to the pending priority. The clear sets the pending priority to 0xFF, lowers the line and rejects the cleared source. Otherwise the pending source stays.
- R7: A current-priority write that is less favored than the old value issues a resend. It also runs the inter-processor check when the inter-processor priority is below the new value. A write that equals the old value issues no notification.
- R8: An inter-processor priority write below the current priority runs the inter-processor check. The check leaves the slot alone if a pending priority is less than or equal to the new value. Otherwise it loads source 2, sets the pending priority to the written value and raises the line.
- R9: End-of-interrupt copies its bits 31:24 into the current priority and pulses the end-of-interrupt notification with its bits 23:0. It also pulses a resend and runs the inter-processor check when the inter-processor priority is below the new current priority.
- R10: A pending source loaded by the inter-processor check is never rejected. This holds whether it is displaced or cleared.
- R11: Reject, resend and end-of-interrupt notifications are single-cycle pulses registered one clock after the command. There is at most one of each per cycle.
- R12: When several strobes are high in one cycle, only the highest in the order accept, end-of-interrupt, current-priority write, inter-processor write, offer takes effect. The others have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pres_valid_i | input | 1 | Offer strobe from the source controller |
| pres_src_i | input | 24 | Offered source number |
| pres_prio_i | input | 8 | Offered priority |
| cppr_we_i | input | 1 | Current-priority write strobe |
| mfrr_we_i | input | 1 | Inter-processor priority write strobe |
| prio_wdata_i | input | 8 | Data for either priority write |
| accept_i | input | 1 | Accept strobe |
| eoi_we_i | input | 1 | End-of-interrupt write strobe |
| eoi_wdata_i | input | 32 | End-of-interrupt word |
| xirr_o | output | 32 | Pending word: current priority and pending source |
| pend_prio_o | output | 8 | Pending priority, 0xFF when empty |
| mfrr_o | output | 8 | Inter-processor priority |
| irq_o | output | 1 | Interrupt line to the core |
| reject_o | output | 1 | Reject pulse |
| reject_src_o | output | 24 | Rejected source number |
| resend_o | output | 1 | Resend request pulse |
| eoi_o | output | 1 | End-of-interrupt pulse to the source controller |
| eoi_src_o | output | 24 | Source number carried by the end-of-interrupt pulse |

## Verification
Some behaviour is checked by the assertions on every cycle. These include the consistency of an empty slot with a low line and a 0xFF pending priority. They also cover the reject that answers an under-favored offer, the state after accept, the notifications after end-of-interrupt, the inter-processor load into an empty slot, and the silence of an equal priority write. Other behaviour can only be shown by the bench's ordered scenarios. One example is whether a displaced source gets rejected, which depends on whether it came from the source controller or from the inter-processor path. Others are the keep-or-clear boundary at equal priorities, the resend-driven inter-processor loads, and strobe precedence.

// File: rtl/irq_pres_pkg.sv
package irq_pres_pkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACC  = 3'd1,
    CMD_EOI  = 3'd2,
    CMD_CPPR = 3'd3,
    CMD_MFRR = 3'd4,
    CMD_PRS  = 3'd5
  } cmd_e;
endpackage

// File: rtl/irq_pres_ipi.sv
module irq_pres_ipi #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic              run_i,
  input  logic [SRC_W-1:0]  xisr_i,
  input  logic [PRIO_W-1:0] pend_i,
  input  logic              own_i,
  input  logic [PRIO_W-1:0] lvl_i,
  output logic              take_o,
  output logic              bump_o
);
  logic busy;
  assign busy   = |xisr_i;
  // an equally or more favored pending interrupt keeps the slot
  assign take_o = run_i && !(busy && (pend_i <= lvl_i));
  assign bump_o = take_o && busy && own_i;
endmodule

// File: rtl/irq_pres_pulse.sv
module irq_pres_pulse #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      data_o  <= valid_i ? data_i : '0;
    end
  end
endmodule

// File: rtl/irq_pres_core.sv
module irq_pres_core
  import irq_pres_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  cmd_e                     cmd_i,
  input  logic [SRC_W-1:0]         pres_src_i,
  input  logic [PRIO_W-1:0]        pres_prio_i,
  input  logic [PRIO_W-1:0]        prio_wdata_i,
  input  logic [PRIO_W+SRC_W-1:0]  eoi_wdata_i,
  input  logic [PRIO_W-1:0]        cppr_i,
  input  logic [SRC_W-1:0]         xisr_i,
  input  logic [PRIO_W-1:0]        pend_i,
  input  logic [PRIO_W-1:0]        mfrr_i,
  input  logic                     own_i,
  input  logic                     irq_i,
  output logic [PRIO_W-1:0]        cppr_o,
  output logic [SRC_W-1:0]         xisr_o,
  output logic [PRIO_W-1:0]        pend_o,
  output logic [PRIO_W-1:0]        mfrr_o,
  output logic                     own_o,
  output logic                     irq_o,
  output logic                     rej_o,
  output logic [SRC_W-1:0]         rej_src_o,
  output logic                     rs_o,
  output logic                     eoi_o,
  output logic [SRC_W-1:0]         eoi_src_o
);
  localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

  logic              busy;
  logic              ipi_run;
  logic [PRIO_W-1:0] ipi_lvl;
  logic              ipi_take;
  logic              ipi_bump;
  logic [PRIO_W-1:0] eoi_cppr;

  assign busy     = |xisr_i;
  assign eoi_cppr = eoi_wdata_i[PRIO_W+SRC_W-1:SRC_W];

  // commands that run the check leave xisr/pend/own untouched beforehand
  always_comb begin
    ipi_run = 1'b0;
    ipi_lvl = mfrr_i;
    unique case (cmd_i)
      CMD_EOI:  ipi_run = mfrr_i < eoi_cppr;
      CMD_CPPR: ipi_run = (prio_wdata_i > cppr_i) && (mfrr_i < prio_wdata_i);
      CMD_MFRR: begin
        ipi_lvl = prio_wdata_i;
        ipi_run = prio_wdata_i < cppr_i;
      end
      default: ;
    endcase
  end

  irq_pres_ipi #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ipi (
    .run_i  (ipi_run),
    .xisr_i (xisr_i),
    .pend_i (pend_i),
    .own_i  (own_i),
    .lvl_i  (ipi_lvl),
    .take_o (ipi_take),
    .bump_o (ipi_bump)
  );

  always_comb begin
    cppr_o    = cppr_i;
    xisr_o    = xisr_i;
    pend_o    = pend_i;
    mfrr_o    = mfrr_i;
    own_o     = own_i;
    irq_o     = irq_i;
    rej_o     = 1'b0;
    rej_src_o = '0;
    rs_o      = 1'b0;
    eoi_o     = 1'b0;
    eoi_src_o = '0;
    unique case (cmd_i)
      CMD_ACC: begin
        cppr_o = pend_i;
        xisr_o = '0;
        pend_o = PRIO_IDLE;
        own_o  = 1'b0;
        irq_o  = 1'b0;
      end
      CMD_EOI: begin
        cppr_o    = eoi_cppr;
        eoi_o     = 1'b1;
        eoi_src_o = eoi_wdata_i[SRC_W-1:0];
        rs_o      = 1'b1;
      end
      CMD_CPPR: begin
        cppr_o = prio_wdata_i;
        if (prio_wdata_i < cppr_i) begin
          if (busy && (prio_wdata_i <= pend_i)) begin
            xisr_o    = '0;
            pend_o    = PRIO_IDLE;
            irq_o     = 1'b0;
            own_o     = 1'b0;
            rej_o     = own_i;
            rej_src_o = own_i ? xisr_i : '0;
          end
        end else if (prio_wdata_i > cppr_i) begin
          rs_o = 1'b1;
        end
      end
      CMD_MFRR: mfrr_o = prio_wdata_i;
      CMD_PRS: begin
        if ((pres_prio_i >= cppr_i) || (busy && (pend_i <= pres_prio_i))) begin
          rej_o     = 1'b1;
          rej_src_o = pres_src_i;
        end else begin
          rej_o     = busy && own_i;
          rej_src_o = (busy && own_i) ? xisr_i : '0;
          xisr_o    = pres_src_i;
          pend_o    = pres_prio_i;
          own_o     = 1'b1;
          irq_o     = 1'b1;
        end
      end
      default: ;
    endcase
    if (ipi_take) begin
      rej_o     = ipi_bump;
      rej_src_o = ipi_bump ? xisr_i : '0;
      xisr_o    = IPI_NUM;
      pend_o    = ipi_lvl;
      own_o     = 1'b0;
      irq_o     = 1'b1;
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irq_pres_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pres_valid_i,
  input  logic [SRC_W-1:0]        pres_src_i,
  input  logic [PRIO_W-1:0]       pres_prio_i,
  input  logic                    cppr_we_i,
  input  logic                    mfrr_we_i,
  input  logic [PRIO_W-1:0]       prio_wdata_i,
  input  logic                    accept_i,
  input  logic                    eoi_we_i,
  input  logic [PRIO_W+SRC_W-1:0] eoi_wdata_i,
  output logic [PRIO_W+SRC_W-1:0] xirr_o,
  output logic [PRIO_W-1:0]       pend_prio_o,
  output logic [PRIO_W-1:0]       mfrr_o,
  output logic                    irq_o,
  output logic                    reject_o,
  output logic [SRC_W-1:0]        reject_src_o,
  output logic                    resend_o,
  output logic                    eoi_o,
  output logic [SRC_W-1:0]        eoi_src_o
);
  localparam int XIRR_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

  cmd_e              cmd;
  logic [PRIO_W-1:0] cppr_q, cppr_d;
  logic [SRC_W-1:0]  xisr_q, xisr_d;
  logic [PRIO_W-1:0] pend_q, pend_d;
  logic [PRIO_W-1:0] mfrr_q, mfrr_d;
  logic              own_q, own_d;
  logic              irq_q, irq_d;
  logic              rej_d, rs_d, eoi_d;
  logic [SRC_W-1:0]  rej_src_d, eoi_src_d;
  logic              rs_q;

  always_comb begin
    if (accept_i)          cmd = CMD_ACC;
    else if (eoi_we_i)     cmd = CMD_EOI;
    else if (cppr_we_i)    cmd = CMD_CPPR;
    else if (mfrr_we_i)    cmd = CMD_MFRR;
    else if (pres_valid_i) cmd = CMD_PRS;
    else                   cmd = CMD_NONE;
  end

  irq_pres_core #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_core (
    .cmd_i        (cmd),
    .pres_src_i   (pres_src_i),
    .pres_prio_i  (pres_prio_i),
    .prio_wdata_i (prio_wdata_i),
    .eoi_wdata_i  (eoi_wdata_i),
    .cppr_i       (cppr_q),
    .xisr_i       (xisr_q),
    .pend_i       (pend_q),
    .mfrr_i       (mfrr_q),
    .own_i        (own_q),
    .irq_i        (irq_q),
    .cppr_o       (cppr_d),
    .xisr_o       (xisr_d),
    .pend_o       (pend_d),
    .mfrr_o       (mfrr_d),
    .own_o        (own_d),
    .irq_o        (irq_d),
    .rej_o        (rej_d),
    .rej_src_o    (rej_src_d),
    .rs_o         (rs_d),
    .eoi_o        (eoi_d),
    .eoi_src_o    (eoi_src_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cppr_q <= '0;
      xisr_q <= '0;
      pend_q <= PRIO_IDLE;
      mfrr_q <= PRIO_IDLE;
      own_q  <= 1'b0;
      irq_q  <= 1'b0;
      rs_q   <= 1'b0;
    end else begin
      cppr_q <= cppr_d;
      xisr_q <= xisr_d;
      pend_q <= pend_d;
      mfrr_q <= mfrr_d;
      own_q  <= own_d;
      irq_q  <= irq_d;
      rs_q   <= rs_d;
    end
  end

  irq_pres_pulse #(.W(SRC_W)) u_rej (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rej_d),
    .data_i  (rej_src_d),
    .valid_o (reject_o),
    .data_o  (reject_src_o)
  );

  irq_pres_pulse #(.W(SRC_W)) u_eoi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (eoi_d),
    .data_i  (eoi_src_d),
    .valid_o (eoi_o),
    .data_o  (eoi_src_o)
  );

  assign xirr_o      = XIRR_W'({cppr_q, xisr_q});
  assign pend_prio_o = pend_q;
  assign mfrr_o      = mfrr_q;
  assign irq_o       = irq_q;
  assign resend_o    = rs_q;

  AST_IDLE_ENCODING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xisr_q == '0) |-> (pend_q == PRIO_IDLE && !irq_q)); // R2
  AST_BUSY_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xisr_q != '0) |-> irq_q); // R2
  AST_REFUSE_REJECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRS && pres_prio_i >= cppr_q) |=>
      (reject_o && reject_src_o == $past(pres_src_i) && $stable(xirr_o))); // R3
  AST_ACCEPT_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ACC) |=>
      (!irq_o && xirr_o[SRC_W-1:0] == '0 && pend_prio_o == PRIO_IDLE)); // R5
  AST_EQUAL_CPPR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_CPPR && prio_wdata_i == cppr_q) |=> (!resend_o && !reject_o)); // R7
  AST_MFRR_LOADS_IPI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_MFRR && prio_wdata_i < cppr_q && xisr_q == '0) |=>
      (xirr_o[SRC_W-1:0] == IPI_NUM && pend_prio_o == $past(prio_wdata_i) && irq_o)); // R8
  AST_EOI_NOTIFIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_EOI) |=>
      (eoi_o && resend_o && eoi_src_o == $past(eoi_wdata_i[SRC_W-1:0]))); // R9
endmodule

// File: tb/irq_presenter_test.sv
module irq_presenter_test;
  localparam logic [2:0] T_NONE = 3'd0, T_ACC = 3'd1, T_EOI = 3'd2,
                         T_CPPR = 3'd3, T_MFRR = 3'd4, T_PRS = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] data;
    logic [31:0] xirr;
    logic [7:0]  pend;
    logic        irq;
    logic        rej;
    logic [23:0] rsrc;
    logic        rs;
    logic        eo;
    logic [23:0] esrc;
  } vec_t;

  localparam int NV = 21;
  // offers: data = {prio, src}; priority writes use data[7:0]
  localparam vec_t VECS [NV] = '{
    '{T_PRS,  32'h05000010, 32'h00000000, 8'hFF, 1'b0, 1'b1, 24'h000010, 1'b0, 1'b0, 24'h0}, // R3 cppr 0
    '{T_CPPR, 32'h000000FF, 32'hFF000000, 8'hFF, 1'b0, 1'b0, 24'h0,      1'b1, 1'b0, 24'h0}, // R7
    '{T_PRS,  32'h05000010, 32'hFF000010, 8'h05, 1'b1, 1'b0, 24'h0,      1'b0, 1'b0, 24'h0}, // R4
    '{T_PRS,  32'h07000020, 32'hFF000010, 8'h05, 1'b1, 1'b1, 24'h000020, 1'b0, 1'b0, 24'h0}, // R3
    '{T_PRS,  32'h03000030, 32'hFF000030, 8'h03, 1'b1, 1'b1, 24'h000010, 1'b0, 1'b0, 24'h0}, // R4 displace
    '{T_PRS,  32'h03000040, 32'hFF000030, 8'h03, 1'b1, 1'b1, 24'h000040, 1'b0, 1'b0, 24'h0}, // R3 equal
    '{T_ACC,  32'h00000000, 32'h03000000, 8'hFF, 1'b0, 1'b0, 24'h0,      1'b0, 1'b0, 24'h0}, // R5
    '{T_EOI,  32'hFF000030, 32'hFF000000, 8'hFF, 1'b0, 1'b0, 24'h0,      1'b1, 1'b1, 24'h000030}, // R9
    '{T_MFRR, 32'h00000004, 32'hFF000002, 8'h04, 1'b1, 1'b0, 24'h0,      1'b0, 1'b0, 24'h0}, // R8
    '{T_PRS,  32'h02000050, 32'hFF000050, 8'h02, 1'b1, 1'b0, 24'h0,      1'b0, 1'b0, 24'h0}, // R10
    '{T_MFRR, 32'h00000003, 32'hFF000050, 8'h02, 1'b1, 1'b0, 24'h0,      1'b0, 1'b0, 24'h0}, // R8 keep
    '{T_MFRR, 32'h00000001, 32'hFF000002, 8'h01, 1'b1, 1'b1, 24'h000050, 1'b0, 1'b0, 24'h0}, // R8
    '{T_CPPR, 32'h00000001, 32'h01000000, 8'hFF, 1'b0, 1'b0, 24'h0,      1'b0, 1'b0, 24'h0}, // R10
    '{T_PRS,  32'h00000060, 32'h01000060, 8'h00, 1'b1, 1'b0, 24'h0,      1'b0, 1'b0, 24'h0}, // R4
    '{T_CPPR, 32'h00000000, 32'h00000000, 8'hFF, 1'b0, 1'b1, 24'h000060, 1'b0, 1'b0, 24'h0}, // R6
    '{T_CPPR, 32'h00000000, 32'h00000000, 8'hFF, 1'b0, 1'b0, 24'h0,      1'b0, 1'b0, 24'h0}, // R7 equal
    '{T_CPPR, 32'h00000008, 32'h08000002, 8'h01, 1'b1, 1'b0, 24'h0,      1'b1, 1'b0, 24'h0}, // R7 ipi
    '{T_ACC,  32'h00000000, 32'h01000000, 8'hFF, 1'b0, 1'b0, 24'h0,      1'b0, 1'b0, 24'h0}, // R5
    '{T_EOI,  32'h06000002, 32'h06000002, 8'h01, 1'b1, 1'b0, 24'h0,      1'b1, 1'b1, 24'h000002}, // R9
    '{T_PRS,  32'h00000070, 32'h06000070, 8'h00, 1'b1, 1'b0, 24'h0,      1'b0, 1'b0, 24'h0}, // R10
    '{T_CPPR, 32'h00000003, 32'h03000070, 8'h00, 1'b1, 1'b0, 24'h0,      1'b0, 1'b0, 24'h0}  // R6 keep
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pres_valid = 1'b0, cppr_we = 1'b0, mfrr_we = 1'b0;
  logic        accept = 1'b0, eoi_we = 1'b0;
  logic [23:0] pres_src = '0;
  logic [7:0]  pres_prio = '0, prio_wdata = '0;
  logic [31:0] eoi_wdata = '0;
  logic [31:0] xirr;
  logic [7:0]  pend, mfrr;
  logic        irq, reject, resend, eoi;
  logic [23:0] reject_src, eoi_src;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_presenter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .pres_valid_i(pres_valid), .pres_src_i(pres_src), .pres_prio_i(pres_prio),
    .cppr_we_i(cppr_we), .mfrr_we_i(mfrr_we), .prio_wdata_i(prio_wdata),
    .accept_i(accept), .eoi_we_i(eoi_we), .eoi_wdata_i(eoi_wdata),
    .xirr_o(xirr), .pend_prio_o(pend), .mfrr_o(mfrr), .irq_o(irq),
    .reject_o(reject), .reject_src_o(reject_src), .resend_o(resend),
    .eoi_o(eoi), .eoi_src_o(eoi_src)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      T_ACC:  return "R5";
      T_EOI:  return "R9";
      T_CPPR: return "R6/R7";
      T_MFRR: return "R8";
      default: return "R3/R4";
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [31:0] d);
    @(negedge clk);
    accept     = (op == T_ACC);
    eoi_we     = (op == T_EOI);
    cppr_we    = (op == T_CPPR);
    mfrr_we    = (op == T_MFRR);
    pres_valid = (op == T_PRS);
    pres_prio  = d[31:24];
    pres_src   = d[23:0];
    prio_wdata = d[7:0];
    eoi_wdata  = d;
    @(negedge clk);
    {accept, eoi_we, cppr_we, mfrr_we, pres_valid} = '0;
  endtask

  task automatic chk_reset();
    chk("R1", "xirr", xirr, 32'h0);
    chk("R1", "pend", {24'h0, pend}, 32'hFF);
    chk("R1", "mfrr", {24'h0, mfrr}, 32'hFF);
    chk("R1", "irq",  {31'h0, irq}, 32'h0);
    chk("R1", "pulses", {29'h0, reject, resend, eoi}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_reset();
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].data);
      chk(tag_of(VECS[i].op), "xirr", xirr, VECS[i].xirr);
      chk(tag_of(VECS[i].op), "pend", {24'h0, pend}, {24'h0, VECS[i].pend});
      chk("R2", "irq", {31'h0, irq}, {31'h0, VECS[i].irq});
      chk("R11", "reject", {31'h0, reject}, {31'h0, VECS[i].rej});
      if (VECS[i].rej) chk("R11", "reject_src", {8'h0, reject_src}, {8'h0, VECS[i].rsrc});
      chk("R11", "resend", {31'h0, resend}, {31'h0, VECS[i].rs});
      chk("R11", "eoi", {31'h0, eoi}, {31'h0, VECS[i].eo});
      if (VECS[i].eo) chk("R9", "eoi_src", {8'h0, eoi_src}, {8'h0, VECS[i].esrc});
    end
    chk("R8", "mfrr", {24'h0, mfrr}, 32'h01);
    // R11: no command, pulses must be gone
    apply(T_NONE, 32'h0);
    chk("R11", "idle pulses", {29'h0, reject, resend, eoi}, 32'h0);
    chk("R11", "idle xirr", xirr, 32'h03000070);
    // R12: accept and offer together, accept wins and offer leaves no trace
    @(negedge clk);
    accept = 1'b1; pres_valid = 1'b1; pres_prio = 8'h00; pres_src = 24'h000080;
    @(negedge clk);
    accept = 1'b0; pres_valid = 1'b0;
    chk("R12", "xirr", xirr, 32'h00000000);
    chk("R12", "pend", {24'h0, pend}, 32'hFF);
    chk("R12", "reject", {31'h0, reject}, 32'h0);
    // R12: end-of-interrupt beats a priority write
    @(negedge clk);
    eoi_we = 1'b1; eoi_wdata = 32'h05000011; cppr_we = 1'b1; prio_wdata = 8'h09;
    @(negedge clk);
    eoi_we = 1'b0; cppr_we = 1'b0;
    chk("R12", "cppr from eoi", xirr, 32'h05000002);
    chk("R12", "eoi_src", {8'h0, eoi_src}, 32'h11);
    // R1: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1 chk_reset();
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog expired: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule